// File: doc/BRIEF.md
# Floppy Controller Host Register File

This block is the byte-wide register interface that a host processor uses to drive a floppy disk controller. The host selects one of sixteen byte offsets, then reads or writes a byte in one clock cycle. One offset takes commands. Two offsets expose a 16-bit status word, and three hold the track, sector and head numbers. One data port moves sector bytes into and out of a 512-byte buffer through a single pointer that advances on its own. The remaining offsets are plain storage.

Only two commands act. A motor spin-up command raises busy for a programmable number of clocks and then drops it. A cancel command drops busy at once. Media commands are accepted and leave all state as it was; the media-side engine that carries them out sits outside this block. Read data is combinational from the selected offset. All state changes take effect on the clock edge that ends the access.

Top module: `fdc_regfile`

## Requirements
- R1: After reset, every offset except the data port (7) reads 0x00, the status word is zero and the buffer pointer is at index 0.
- R2: A byte written to offset 1 reads back unchanged from offset 1. It is decoded after an AND with 0xF9, so bits 1 and 2 do not change its meaning (0x26 acts as 0x20, and 0x06 acts as 0x00).
- R3: A write of masked command 0x20 sets busy (status bit 7) from the next cycle on. Busy holds for exactly SPIN_CYCLES cycles and then clears by itself. The lost-data (bit 2), CRC (bit 3), not-found (bit 4) and interrupt (bit 9) flags are left clear.
- R4: A write of masked command 0x00 clears busy in the next cycle and stops the timer, so busy does not return.
- R5: Any other masked command, including 0x30, 0x31, 0x40, 0x41, 0x80 and 0x81, leaves the status word and the running timer unchanged. A busy period still ends on its original cycle.
- R6: Offset 2 reads status bits 7:0 and offset 3 reads status bits 15:8. Writes to offsets 2 and 3 are ignored.
- R7: Offsets 4, 5 and 6 (track, sector, head) read back the last byte written to them.
- R8: Every access to offset 7, read or write, uses the buffer byte at one shared pointer and then advances that pointer by one. A write stores the byte there, and a read returns it.
- R9: The buffer pointer wraps from index BUF_DEPTH-1 (511) to 0.
- R10: Offsets 0 and 8 to 15 are independent storage bytes that read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Access strobe; one access per cycle while high |
| wr | input | 1 | 1 = write access, 0 = read access |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected offset (combinational) |

## Verification
The busy period is probed by reading status every cycle after a spin-up. This pins down the exact cycle busy clears and separates an off-by-one timer from a correct one. The same sweep is repeated with each acknowledged-only code, and with masked variants, written halfway through. These runs tell a command that wrongly restarts or stops the timer apart from one that leaves it alone. The cancel runs check that busy drops and stays down. A full 512-byte write and read-back with an address-dependent pattern, followed by mixed reads and writes, shows that the pointer is shared, advances once per access and wraps at the buffer end.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  localparam logic [7:0] CMD_MASK   = 8'hF9;
  localparam logic [7:0] CMD_SPINUP = 8'h20;
  localparam logic [7:0] CMD_CANCEL = 8'h00;

  localparam int ST_LOST = 2;
  localparam int ST_CRC  = 3;
  localparam int ST_RNF  = 4;
  localparam int ST_BUSY = 7;
  localparam int ST_IRQ  = 9;

  localparam int OFS_CMD  = 1;
  localparam int OFS_STLO = 2;
  localparam int OFS_STHI = 3;
  localparam int OFS_TRK  = 4;
  localparam int OFS_SEC  = 5;
  localparam int OFS_HEAD = 6;
  localparam int OFS_DATA = 7;

  typedef enum logic [1:0] {
    CK_CANCEL = 2'd0,
    CK_SPINUP = 2'd1,
    CK_ACK    = 2'd2,
    CK_OTHER  = 2'd3
  } cmd_kind_e;

  function automatic logic [7:0] mask_cmd(input logic [7:0] raw);
    return raw & CMD_MASK;
  endfunction

  function automatic cmd_kind_e classify_cmd(input logic [7:0] raw);
    logic [7:0] m;
    m = mask_cmd(raw);
    case (m)
      CMD_CANCEL:                     return CK_CANCEL;
      CMD_SPINUP:                     return CK_SPINUP;
      8'h30, 8'h31, 8'h40, 8'h41,
      8'h80, 8'h81:                   return CK_ACK;
      default:                        return CK_OTHER;
    endcase
  endfunction

  function automatic int unsigned next_index(input int unsigned p,
                                             input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Offsets that hold a plain stored byte (not status, not data port)
  function automatic bit is_storage(input int ofs);
    return !(ofs == OFS_STLO || ofs == OFS_STHI || ofs == OFS_DATA);
  endfunction

endpackage

// File: rtl/fdc_cmd_ctrl.sv
module fdc_cmd_ctrl
  import fdc_pkg::*;
#(
  parameter int SPIN_CYCLES = 2000,
  localparam int CNT_W = $clog2(SPIN_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [7:0]  cmd_data,
  output logic [15:0] status
);

  cmd_kind_e   kind;
  logic        spin_start;
  logic        cancel_hit;
  logic        timer_done;
  logic        busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0] flags_q;

  assign kind       = classify_cmd(cmd_data);
  assign spin_start = cmd_we && (kind == CK_SPINUP);
  assign cancel_hit = cmd_we && (kind == CK_CANCEL);
  assign timer_done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      flags_q <= '0;
    end else if (spin_start) begin
      busy_q           <= 1'b1;
      cnt_q            <= CNT_W'(SPIN_CYCLES - 1);
      flags_q[ST_LOST] <= 1'b0;
      flags_q[ST_CRC]  <= 1'b0;
      flags_q[ST_RNF]  <= 1'b0;
      flags_q[ST_IRQ]  <= 1'b0;
    end else if (cancel_hit) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (timer_done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    status          = flags_q;
    status[ST_BUSY] = busy_q;
  end

  // R3
  spin_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spin_start |=> status[ST_BUSY]);
  // R3
  spin_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spin_start |=> (status[ST_LOST] == 1'b0 && status[ST_CRC] == 1'b0 &&
                    status[ST_RNF] == 1'b0 && status[ST_IRQ] == 1'b0));
  // R3
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_done && !cmd_we) |=> !status[ST_BUSY]);
  // R4
  cancel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_hit |=> !status[ST_BUSY]);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_BUSY] && !timer_done && !cancel_hit) |=> status[ST_BUSY]);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[ST_BUSY] && !spin_start) |=> !status[ST_BUSY]);

endmodule

// File: rtl/fdc_sector_buf.sv
module fdc_sector_buf
  import fdc_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_hit,
  input  logic       port_we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic             at_end;

  assign at_end = (ptr_q == PTR_W'(DEPTH - 1));
  assign rdata  = mem[ptr_q];

  always_ff @(posedge clk) begin
    if (port_hit && port_we) mem[ptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (port_hit) ptr_q <= PTR_W'(next_index(int'(ptr_q), DEPTH));
  end

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_hit && at_end) |=> (ptr_q == '0));
  // R8
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_hit |=> $stable(ptr_q));
  // R8
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_hit |=> !$stable(ptr_q));

endmodule

// File: rtl/fdc_reg_bank.sv
module fdc_reg_bank
  import fdc_pkg::*;
#(
  parameter int NREG = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  output logic [NREG*8-1:0] regs
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (is_storage(g)) begin : g_store
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        q <= '0;
        else if (we && addr == AW'(g))     q <= wdata;
      end
      assign regs[g*8 +: 8] = q;
    end else begin : g_none
      assign regs[g*8 +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/fdc_regfile.sv
module fdc_regfile
  import fdc_pkg::*;
#(
  parameter int BUF_DEPTH   = 512,
  parameter int SPIN_CYCLES = 2000,
  parameter int NREG        = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic              wr_acc;
  logic              cmd_we;
  logic              port_hit;
  logic [15:0]       status;
  logic [7:0]        buf_rdata;
  logic [NREG*8-1:0] regs;

  assign wr_acc   = sel && wr;
  assign cmd_we   = wr_acc && (addr == AW'(OFS_CMD));
  assign port_hit = sel && (addr == AW'(OFS_DATA));

  fdc_cmd_ctrl #(.SPIN_CYCLES(SPIN_CYCLES)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cmd_we),
    .cmd_data (wdata),
    .status   (status)
  );

  fdc_sector_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_hit (port_hit),
    .port_we  (wr),
    .wdata    (wdata),
    .rdata    (buf_rdata)
  );

  fdc_reg_bank #(.NREG(NREG)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_acc),
    .addr  (addr),
    .wdata (wdata),
    .regs  (regs)
  );

  always_comb begin
    if (addr == AW'(OFS_STLO))      rdata = status[7:0];
    else if (addr == AW'(OFS_STHI)) rdata = status[15:8];
    else if (addr == AW'(OFS_DATA)) rdata = buf_rdata;
    else                            rdata = regs[addr*8 +: 8];
  end

  // R6
  status_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && (addr == AW'(OFS_STLO) || addr == AW'(OFS_STHI)))
      |=> (status == $past(status) || status[7] != $past(status[7])));
  // R7
  trk_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && addr == AW'(OFS_TRK)) |=> (regs[OFS_TRK*8 +: 8] == $past(wdata)));

endmodule

// File: tb/fdc_regfile_bench.sv
module fdc_regfile_bench;

  localparam int SPIN  = 24;
  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fdc_regfile #(.BUF_DEPTH(DEPTH), .SPIN_CYCLES(SPIN)) u_fdc_regfile (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic access(input logic w, input logic [3:0] a,
                        input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    sel = 1'b1; wr = w; addr = a; wdata = d;
    #1 q = rdata;
    @(posedge clk);
    #1 sel = 1'b0; wr = 1'b0;
  endtask

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) ^ (i >> 8));
  endfunction

  // spin-up then sweep status; at slot `ins` write `code` instead of reading
  task automatic spin_sweep(input logic [7:0] code, input int ins, input string req);
    logic [7:0] q;
    access(1'b1, 4'd1, 8'h20, q);
    for (int k = 1; k <= SPIN + 2; k++) begin
      if (k == ins) access(1'b1, 4'd1, code, q);
      else begin
        access(1'b0, 4'd2, 8'h00, q);
        check(req, q, (k <= SPIN) ? 8'h80 : 8'h00);
      end
    end
  endtask

  initial begin
    logic [7:0] q;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      if (a != 7) begin
        access(1'b0, 4'(a), 8'h00, q);
        check("R1", q, 8'h00);
      end
    end

    // R7 / R10 storage sweep
    for (int a = 0; a < 16; a++)
      if (a != 1 && a != 2 && a != 3 && a != 7)
        access(1'b1, 4'(a), 8'((a * 17) ^ 8'h5A), q);
    for (int a = 0; a < 16; a++) begin
      if (a == 4 || a == 5 || a == 6) begin
        access(1'b0, 4'(a), 8'h00, q);
        check("R7", q, 8'((a * 17) ^ 8'h5A));
      end else if (a == 0 || a >= 8) begin
        access(1'b0, 4'(a), 8'h00, q);
        check("R10", q, 8'((a * 17) ^ 8'h5A));
      end
    end

    // R6 writes to status offsets ignored
    access(1'b1, 4'd2, 8'hFF, q);
    access(1'b1, 4'd3, 8'hFF, q);
    access(1'b0, 4'd2, 8'h00, q); check("R6", q, 8'h00);
    access(1'b0, 4'd3, 8'h00, q); check("R6", q, 8'h00);

    // R2 + R3: masked spin-up variant 0x26, exact busy window
    access(1'b1, 4'd1, 8'h26, q);
    for (int k = 1; k <= SPIN + 2; k++) begin
      access(1'b0, 4'd2, 8'h00, q);
      check("R3", q, (k <= SPIN) ? 8'h80 : 8'h00);
      if (k == 3) begin
        access(1'b0, 4'd3, 8'h00, q);
        check("R6", q, 8'h00);
        k++;
      end
    end
    access(1'b0, 4'd1, 8'h00, q);
    check("R2", q, 8'h26);

    // R5 acknowledged and unknown codes leave timer alone
    spin_sweep(8'h40, 5, "R5");
    spin_sweep(8'h41, 6, "R5");
    spin_sweep(8'h80, 7, "R5");
    spin_sweep(8'h81, 8, "R5");
    spin_sweep(8'h30, 9, "R5");
    spin_sweep(8'h31, 10, "R5");
    spin_sweep(8'h46, 11, "R5");
    spin_sweep(8'h08, 12, "R5");
    access(1'b0, 4'd1, 8'h00, q);
    check("R2", q, 8'h08);

    // R4 cancel (0x06 masks to 0x00)
    access(1'b1, 4'd1, 8'h20, q);
    for (int k = 0; k < 3; k++) begin
      access(1'b0, 4'd2, 8'h00, q); check("R3", q, 8'h80);
    end
    access(1'b1, 4'd1, 8'h06, q);
    for (int k = 0; k < SPIN + 2; k++) begin
      access(1'b0, 4'd2, 8'h00, q); check("R4", q, 8'h00);
    end

    // R8 / R9 data port
    for (int i = 0; i < DEPTH; i++) access(1'b1, 4'd7, pat(i), q);
    for (int i = 0; i < DEPTH; i++) begin
      access(1'b0, 4'd7, 8'h00, q); check("R9", q, pat(i));
    end
    access(1'b1, 4'd7, 8'hAA, q);
    access(1'b0, 4'd7, 8'h00, q); check("R8", q, pat(1));
    access(1'b0, 4'd7, 8'h00, q); check("R8", q, pat(2));
    access(1'b1, 4'd7, 8'h55, q);
    for (int i = 4; i < DEPTH; i++) access(1'b0, 4'd7, 8'h00, q);
    access(1'b0, 4'd7, 8'h00, q); check("R9", q, 8'hAA);
    access(1'b0, 4'd7, 8'h00, q); check("R8", q, pat(1));
    access(1'b0, 4'd7, 8'h00, q); check("R8", q, pat(2));
    access(1'b0, 4'd7, 8'h00, q); check("R8", q, 8'h55);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule